// File: doc/BRIEF.md
# Remote Examine/Deposit Sequencer

This block lets a 16-bit front-end processor read (examine) or write (deposit) one 36-bit word in a host's memory over a shared request/command bus. The front end fills five 16-bit mailbox words: three data words and two address words. A write to the second address word starts the operation.

The sequencer then steps through timed minor states of eight clock cycles each. It loads both address words into a 36-bit shift buffer and raises a level-0 interrupt request. When the host polls, it presents a command word. After that it moves data between the buffer and the three data words. For an examine, the host writes the fetched word into the buffer and the sequencer unpacks it into the data words. For a deposit, the sequencer packs the data words into the buffer and holds until the host reads it.

A protection-off flip-flop shadows one bit of the first address word. It is cleared after every operation, so a repeated operation is protected unless that word is written again.

Top module: `remote_exdep`

## Requirements
- R1: A front-end write to mailbox select 4 (address word 2) sets the start flag. `start_inv` reads 0 from the next cycle until the operation ends, and reads 1 after reset and after an operation completes.
- R2: The two address minor states last 8 cycles each. `host_irq` rises 17 clock edges after the edge that wrote address word 2.
- R3: During a poll (`host_poll` high while the request is pending), `bus_xfer` is 1 and `bus_data` carries the command word. Bits [35:33] are the address space (address word 1 bits 15:13). Bits [32:30] are the function, 100 for examine and 101 for deposit, taken from address word 1 bit 12. Bit [29] is the inverse of protection-off. Bits [28:24] are 0. Bits [23:0] are {address word 1 bits 7:0, address word 2}.
- R4: `host_irq` drops on the edge after the poll is first seen. The sequencer moves on only after `host_poll` falls.
- R5: For an examine, the 36-bit word written with `host_wr` is stored in the mailbox as follows: data word 1 (select 0) = {12'b0, bits 35:32}, data word 2 (select 1) = bits 31:16, data word 3 (select 2) = bits 15:0.
- R6: For a deposit, the data words are packed as {word1[3:0], word2, word3}. The sequencer holds until `host_rd` is high, then drives that word on `bus_data` with `bus_xfer` = 1.
- R7: Protection-off is loaded from bit 11 only when address word 1 (select 3) is written, and is cleared when an operation completes. An operation started again without rewriting address word 1 shows command bit 29 = 1.
- R8: `done_o` is high for exactly 8 cycles at the end of each operation, after which the block is idle.
- R9: The sequencer never alters the address words, and a deposit leaves the data words unchanged.
- R10: Master reset (`rst`) at any point returns the block to idle. It clears the mailbox, the start flag and protection-off, and drops `host_irq`, `bus_xfer` and `done_o`.
- R11: `bus_xfer` is high only while `host_poll` or `host_rd` is high, and `bus_data` is 0 whenever `bus_xfer` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| mb_we | input | 1 | Front-end mailbox write strobe |
| mb_sel | input | 3 | Mailbox select for writes (0-2 data, 3-4 address) |
| mb_wdata | input | 16 | Mailbox write data |
| mb_rsel | input | 3 | Mailbox select for reads |
| mb_rdata | output | 16 | Mailbox read data |
| start_inv | output | 1 | Inverted start flag (1 = idle) |
| host_irq | output | 1 | Level-0 interrupt request to the host |
| host_poll | input | 1 | Host demand for the command word |
| host_rd | input | 1 | Host demand for deposit data |
| host_wr | input | 1 | Host strobe delivering examine data |
| host_wdata | input | 36 | Examine data from the host |
| bus_xfer | output | 1 | Transfer valid on bus_data |
| bus_data | output | 36 | Command word or deposit data |
| done_o | output | 1 | Operation-complete indication, one 8-cycle period |

## Verification
Two events can fall in the same cycle: the host poll and the pending request. In the first cycle of a poll, `host_irq` and `bus_xfer` are both high and the command word is on the bus. The bench raises `host_poll` as soon as the request appears. It compares the command word in that same cycle and checks on the next cycle that the request has dropped. A master reset landing in the middle of an operation is also provoked. There the bench checks that the idle state and the protection-off clearing win over the operation in flight.

// File: rtl/xd_pkg.sv
package xd_pkg;
    localparam int MB_W   = 16;
    localparam int BUF_W  = 36;
    localparam int MB_N   = 5;

    localparam logic [2:0] SEL_D1 = 3'd0;
    localparam logic [2:0] SEL_D2 = 3'd1;
    localparam logic [2:0] SEL_D3 = 3'd2;
    localparam logic [2:0] SEL_A1 = 3'd3;
    localparam logic [2:0] SEL_A2 = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_ADR1, S_ADR2, S_REQ, S_EXW,
        S_WD1, S_WD2, S_WD3, S_DPW, S_DONE
    } xd_state_e;

    typedef enum logic [1:0] {
        B_HOLD,   // keep contents
        B_SHLD,   // shift left one word, load feed into low word
        B_SHIFT,  // shift left one word, zero fill
        B_HOST    // load whole word from host
    } buf_op_e;

    // Command word presented to the host on a poll
    function automatic logic [BUF_W-1:0] mk_cmd(input logic [BUF_W-1:0] b,
                                                input logic dep,
                                                input logic prot_off);
        return {b[31:29], 2'b10, dep, ~prot_off, 5'b00000, b[23:0]};
    endfunction
endpackage

// File: rtl/xd_mailbox.sv
module xd_mailbox
    import xd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [2:0]      sel,
    input  logic [MB_W-1:0] wdata,
    input  logic            seq_we,
    input  logic [2:0]      seq_sel,
    input  logic [MB_W-1:0] seq_wdata,
    input  logic            op_end,
    input  logic [2:0]      rsel,
    output logic [MB_W-1:0] rdata,
    input  logic [2:0]      feed_sel,
    output logic [MB_W-1:0] feed,
    output logic            dep_bit,
    output logic            start,
    output logic            prot_off
);
    logic [MB_W-1:0] mb [MB_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MB_N; i++) mb[i] <= '0;
            start    <= 1'b0;
            prot_off <= 1'b0;
        end else begin
            for (int i = 0; i < MB_N; i++) begin
                if (we && sel == 3'(i))
                    mb[i] <= wdata;
                else if (seq_we && seq_sel == 3'(i))
                    mb[i] <= seq_wdata;
            end
            if (we && sel == SEL_A2)      start <= 1'b1;
            else if (op_end)              start <= 1'b0;
            if (we && sel == SEL_A1)      prot_off <= wdata[11];
            else if (op_end)              prot_off <= 1'b0;
        end
    end

    always_comb begin
        rdata = (rsel < 3'(MB_N)) ? mb[rsel] : '0;
        feed  = (feed_sel < 3'(MB_N)) ? mb[feed_sel] : '0;
    end

    assign dep_bit = mb[SEL_A1][12];
endmodule

// File: rtl/xd_buffer.sv
module xd_buffer
    import xd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  buf_op_e          op,
    input  logic [MB_W-1:0]  feed,
    input  logic [BUF_W-1:0] host_wdata,
    input  logic             wb_hi,
    output logic [BUF_W-1:0] buf_q,
    output logic [MB_W-1:0]  wb_data
);
    always_ff @(posedge clk) begin
        if (rst) buf_q <= '0;
        else begin
            unique case (op)
                B_SHLD:  buf_q <= {buf_q[BUF_W-MB_W-1:0], feed};
                B_SHIFT: buf_q <= {buf_q[BUF_W-MB_W-1:0], {MB_W{1'b0}}};
                B_HOST:  buf_q <= host_wdata;
                default: buf_q <= buf_q;
            endcase
        end
    end

    // Write-back source: top nibble for word 1, next 16 bits otherwise
    assign wb_data = wb_hi ? buf_q[BUF_W-5 -: MB_W]
                           : {{(MB_W-4){1'b0}}, buf_q[BUF_W-1 -: 4]};
endmodule

// File: rtl/xd_seq.sv
module xd_seq
    import xd_pkg::*;
#(
    parameter int TICKS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       dep_bit,
    input  logic       host_poll,
    input  logic       host_rd,
    input  logic       host_wr,
    output buf_op_e    buf_op,
    output logic [2:0] feed_sel,
    output logic       seq_we,
    output logic [2:0] seq_sel,
    output logic       wb_hi,
    output logic       op_end,
    output logic       is_dep,
    output logic       irq,
    output logic       xfer_cmd,
    output logic       xfer_dat,
    output logic       busy_done
);
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

    xd_state_e       state, nxt;
    logic [TW-1:0]   tick;
    logic            served;
    logic            last;

    assign last = (tick == TW'(TICKS - 1));

    always_comb begin
        nxt      = state;
        buf_op   = B_HOLD;
        feed_sel = SEL_A1;
        seq_we   = 1'b0;
        seq_sel  = SEL_D1;
        wb_hi    = 1'b0;
        op_end   = 1'b0;
        unique case (state)
            S_IDLE: if (start) nxt = S_ADR1;
            S_ADR1: if (last) begin buf_op = B_SHLD; nxt = S_ADR2; end
            S_ADR2: begin
                feed_sel = SEL_A2;
                if (last) begin buf_op = B_SHLD; nxt = S_REQ; end
            end
            S_REQ:  if (served && !host_poll) nxt = is_dep ? S_WD1 : S_EXW;
            S_EXW:  if (host_wr) begin buf_op = B_HOST; nxt = S_WD1; end
            S_WD1: begin
                feed_sel = SEL_D1;
                if (last) begin
                    nxt = S_WD2;
                    if (is_dep) buf_op = B_SHLD;
                    else begin seq_we = 1'b1; seq_sel = SEL_D1; end
                end
            end
            S_WD2: begin
                feed_sel = SEL_D2;
                if (last) begin
                    nxt = S_WD3;
                    if (is_dep) buf_op = B_SHLD;
                    else begin
                        buf_op = B_SHIFT; seq_we = 1'b1;
                        seq_sel = SEL_D2; wb_hi = 1'b1;
                    end
                end
            end
            S_WD3: begin
                feed_sel = SEL_D3;
                if (last) begin
                    nxt = is_dep ? S_DPW : S_DONE;
                    if (is_dep) buf_op = B_SHLD;
                    else begin seq_we = 1'b1; seq_sel = SEL_D3; wb_hi = 1'b1; end
                end
            end
            S_DPW:  if (served && !host_rd) nxt = S_DONE;
            S_DONE: if (last) begin op_end = 1'b1; nxt = S_IDLE; end
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            tick   <= '0;
            served <= 1'b0;
            is_dep <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state) tick <= '0;
            else if (state inside {S_ADR1, S_ADR2, S_WD1, S_WD2, S_WD3, S_DONE})
                tick <= tick + 1'b1;
            if (nxt != state) served <= 1'b0;
            else if (xfer_cmd || xfer_dat) served <= 1'b1;
            if (state == S_ADR1 && last) is_dep <= dep_bit;
        end
    end

    assign irq       = (state == S_REQ) && !served;
    assign xfer_cmd  = (state == S_REQ) && host_poll;
    assign xfer_dat  = (state == S_DPW) && host_rd;
    assign busy_done = (state == S_DONE);
endmodule

// File: rtl/remote_exdep.sv
module remote_exdep
    import xd_pkg::*;
#(
    parameter int TICKS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mb_we,
    input  logic [2:0]       mb_sel,
    input  logic [MB_W-1:0]  mb_wdata,
    input  logic [2:0]       mb_rsel,
    output logic [MB_W-1:0]  mb_rdata,
    output logic             start_inv,
    output logic             host_irq,
    input  logic             host_poll,
    input  logic             host_rd,
    input  logic             host_wr,
    input  logic [BUF_W-1:0] host_wdata,
    output logic             bus_xfer,
    output logic [BUF_W-1:0] bus_data,
    output logic             done_o
);
    buf_op_e          buf_op;
    logic [2:0]       feed_sel, seq_sel;
    logic [MB_W-1:0]  feed, wb_data;
    logic             seq_we, wb_hi, op_end, is_dep, dep_bit;
    logic             start, prot_off, xfer_cmd, xfer_dat;
    logic [BUF_W-1:0] buf_q;

    xd_mailbox u_mb (
        .clk(clk), .rst(rst), .we(mb_we), .sel(mb_sel), .wdata(mb_wdata),
        .seq_we(seq_we), .seq_sel(seq_sel), .seq_wdata(wb_data),
        .op_end(op_end), .rsel(mb_rsel), .rdata(mb_rdata),
        .feed_sel(feed_sel), .feed(feed), .dep_bit(dep_bit),
        .start(start), .prot_off(prot_off)
    );

    xd_seq #(.TICKS(TICKS)) u_seq (
        .clk(clk), .rst(rst), .start(start), .dep_bit(dep_bit),
        .host_poll(host_poll), .host_rd(host_rd), .host_wr(host_wr),
        .buf_op(buf_op), .feed_sel(feed_sel), .seq_we(seq_we),
        .seq_sel(seq_sel), .wb_hi(wb_hi), .op_end(op_end), .is_dep(is_dep),
        .irq(host_irq), .xfer_cmd(xfer_cmd), .xfer_dat(xfer_dat),
        .busy_done(done_o)
    );

    xd_buffer u_buf (
        .clk(clk), .rst(rst), .op(buf_op), .feed(feed),
        .host_wdata(host_wdata), .wb_hi(wb_hi),
        .buf_q(buf_q), .wb_data(wb_data)
    );

    assign start_inv = ~start;
    assign bus_xfer  = xfer_cmd | xfer_dat;
    assign bus_data  = xfer_cmd ? mk_cmd(buf_q, is_dep, prot_off)
                     : xfer_dat ? buf_q : '0;
endmodule

// File: rtl/xd_chk.sv
module xd_chk (
    input logic        clk,
    input logic        rst,
    input logic        mb_we,
    input logic [2:0]  mb_sel,
    input logic        start_inv,
    input logic        host_irq,
    input logic        host_poll,
    input logic        host_rd,
    input logic        bus_xfer,
    input logic [35:0] bus_data,
    input logic        done_o
);
    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> (start_inv && !host_irq && !done_o && !bus_xfer));

    p_start_go_r1: assert property (@(posedge clk) disable iff (rst)
        (mb_we && mb_sel == 3'd4) |=> !start_inv);

    p_cmd_shape_r3: assert property (@(posedge clk) disable iff (rst)
        (host_irq && host_poll) |-> (bus_xfer && bus_data[32:31] == 2'b10
                                     && bus_data[28:24] == 5'd0));

    p_irq_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (host_irq && host_poll) |=> !host_irq);

    p_done_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !start_inv);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(done_o) && !$past(mb_we)) |-> start_inv);

    p_xfer_demand_r11: assert property (@(posedge clk) disable iff (rst)
        bus_xfer |-> (host_poll || host_rd));
endmodule

bind remote_exdep xd_chk u_chk (.*);

// File: tb/remote_exdep_test.sv
module remote_exdep_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mb_we = 1'b0;
    logic [2:0]  mb_sel = '0;
    logic [15:0] mb_wdata = '0;
    logic [2:0]  mb_rsel = '0;
    logic [15:0] mb_rdata;
    logic        start_inv, host_irq, bus_xfer, done_o;
    logic        host_poll = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
    logic [35:0] host_wdata = '0;
    logic [35:0] bus_data;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    remote_exdep uut (.*);

    // {dep, prot, space[2:0], addr[22:0], data[35:0]}
    localparam logic [63:0] VEC [0:3] = '{
        {1'b0, 1'b0, 3'b010, 23'h123456, 36'h987654321},
        {1'b1, 1'b1, 3'b101, 23'h7F0F0F, 36'hF0123ABCD},
        {1'b1, 1'b0, 3'b000, 23'h000001, 36'h0FFFF0000},
        {1'b0, 1'b1, 3'b111, 23'h55AAAA, 36'hA5A5AC3C3}
    };

    task automatic chk(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk); mb_we = 1'b1; mb_sel = s; mb_wdata = d;
        @(negedge clk); mb_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [15:0] v);
        mb_rsel = s; #1; v = mb_rdata;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!host_irq && n < 200) begin @(negedge clk); n++; end
    endtask

    task automatic pulse_rst();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic poll(output logic [35:0] c, output logic xf, output logic irq_after);
        @(negedge clk); host_poll = 1'b1; #1; c = bus_data; xf = bus_xfer;
        @(negedge clk); #1; irq_after = host_irq; host_poll = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [35:0] c;
        logic xf, ia;
        int n;
        logic [15:0] a1_last, a2_last;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: reset state
        chk(start_inv && !host_irq && !done_o && !bus_xfer && bus_data == 0,
            "R10 reset idle", {start_inv, host_irq, done_o, bus_xfer}, 4'b1000);

        for (int i = 0; i < 4; i++) begin
            logic dep, prot;
            logic [2:0] sp;
            logic [22:0] ad;
            logic [35:0] dt, expc;
            logic [15:0] a1, a2, d1, d2, d3;
            {dep, prot, sp, ad, dt} = VEC[i];
            a1 = {sp, dep, prot, 4'b0, ad[22:16]};
            a2 = ad[15:0];
            d1 = {12'h5A3, dt[35:32]};
            d2 = dt[31:16];
            d3 = dt[15:0];
            expc = {sp, 2'b10, dep, ~prot, 5'b0, 1'b0, ad};
            if (dep) begin wr(3'd0, d1); wr(3'd1, d2); wr(3'd2, d3); end
            wr(3'd3, a1);
            wr(3'd4, a2);
            chk(!start_inv, "R1 start flag set", start_inv, 0);
            wait_irq(n);
            chk(n == 17, "R2 request timing", n, 17);
            chk(!bus_xfer && bus_data == 0, "R11 idle bus", bus_data, 0);
            poll(c, xf, ia);
            chk(xf && c == expc, "R3 R7 command word", c, expc);
            chk(!ia, "R4 request drops after poll", ia, 0);
            if (!dep) begin
                @(negedge clk); host_wr = 1'b1; host_wdata = dt;
                @(negedge clk); host_wr = 1'b0;
            end else begin
                @(negedge clk); host_rd = 1'b1;
                n = 0;
                while (!bus_xfer && n < 200) begin @(negedge clk); n++; end
                #1;
                chk(bus_xfer && bus_data == dt, "R6 deposit data", bus_data, dt);
                @(negedge clk); host_rd = 1'b0;
            end
            n = 0;
            while (!done_o && n < 200) begin @(negedge clk); n++; end
            n = 0;
            while (done_o && n < 50) begin @(negedge clk); n++; end
            chk(n == 8, "R8 done length", n, 8);
            chk(start_inv, "R1 start clears at end", start_inv, 1);
            if (!dep) begin
                rd(3'd0, v); chk(v == {12'b0, dt[35:32]}, "R5 word1", v, {12'b0, dt[35:32]});
                rd(3'd1, v); chk(v == dt[31:16], "R5 word2", v, dt[31:16]);
                rd(3'd2, v); chk(v == dt[15:0], "R5 word3", v, dt[15:0]);
            end else begin
                rd(3'd0, v); chk(v == d1, "R9 deposit word1 kept", v, d1);
                rd(3'd1, v); chk(v == d2, "R9 deposit word2 kept", v, d2);
                rd(3'd2, v); chk(v == d3, "R9 deposit word3 kept", v, d3);
            end
            rd(3'd3, v); chk(v == a1, "R9 address1 kept", v, a1);
            rd(3'd4, v); chk(v == a2, "R9 address2 kept", v, a2);
            a1_last = a1; a2_last = a2;
        end

        // R7: last vector had protection-off set; repeat without rewriting address1
        wr(3'd4, a2_last);
        wait_irq(n);
        poll(c, xf, ia);
        chk(c[29] == 1'b1, "R7 repeat is protected", c[29], 1);
        rd(3'd3, v); chk(v[11] == 1'b1, "R7 stored bit kept", v[11], 1);

        // R10: reset in the middle of an operation
        pulse_rst(); #1;
        chk(start_inv && !host_irq && !done_o && !bus_xfer, "R10 abort idle",
            {start_inv, host_irq, done_o, bus_xfer}, 4'b1000);
        rd(3'd3, v); chk(v == 0, "R10 mailbox cleared", v, 0);

        // R10: reset clears protection-off loaded before it
        wr(3'd3, 16'h0800);
        pulse_rst();
        wr(3'd4, 16'h0042);
        wait_irq(n);
        chk(n == 17, "R2 request timing after reset", n, 17);
        poll(c, xf, ia);
        chk(c[29] == 1'b1, "R10 protection cleared by reset", c[29], 1);
        chk(c[32:30] == 3'b100, "R3 examine function", c[32:30], 3'b100);
        pulse_rst(); #1;
        chk(start_inv && !host_irq, "R10 final idle", {start_inv, host_irq}, 2'b10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule